// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block hands out regions of a shared endpoint FIFO memory. The memory is split into fixed 512-byte units, and one bit per unit records whether it is taken. A caller asks for space by giving an endpoint's maximum packet size and an extra-slot count. The block rounds the packet size up to a power of two to get the segment size. It multiplies that by the slot count plus one to get the total size, and turns the total into a unit count. It then scans for the lowest run of free units that fits below a runtime limit, marks that run used, and returns the byte address of the region.

A separate single-cycle port returns a run of units to the free pool. One instance serves one direction, so a device would use one instance for transmit FIFOs and another for receive FIFOs. Each instance has its own base address and its own limit. The search tests one candidate start offset per cycle. The caller waits for a one-cycle grant pulse that carries a success flag, the address, the unit offset and the unit count.

Top module: `fifo_seg_alloc`

## Requirements
- R1: After reset every unit is free, `busy` is low and `gnt_valid` is low.
- R2: The unit count is ceil(((slot+1) x S) / 512), where S is the smallest power of two not below the max packet size (S is 1 for a size of 0 or 1). The count is never less than one, and it is reported on `gnt_units` with every grant.
- R3: The granted run is the lowest-offset run of free units that lies entirely below the effective limit. The effective limit is `cfg_limit` capped at the bitmap size of 128 units. A run that ends exactly at the limit is allowed.
- R4: A successful grant reports the start unit on `gnt_offset` and the address `cfg_base + gnt_offset*512` on `gnt_addr`.
- R5: When no run fits, the grant has `gnt_ok` low and `gnt_addr` and `gnt_offset` zero, and no unit changes state.
- R6: A free request clears exactly the units from `free_offset` through `free_offset+free_units-1`. Freeing units that are already free changes nothing.
- R7: A request is accepted only while `busy` is low. `busy` stays high from acceptance until the grant. Requests made while `busy` is high are dropped. `gnt_valid` is a one-cycle pulse, and `busy` falls in the same cycle.
- R8: Granted units stay marked used and are not granted again until they are freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Byte address of unit 0 |
| cfg_limit | input | log2(UNITS)+1 | Number of usable units |
| req_valid | input | 1 | Allocate request, taken when busy is low |
| req_maxp | input | MAXP_W | Endpoint max packet size in bytes |
| req_slot | input | SLOT_W | Extra slot count |
| busy | output | 1 | Search in progress |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_ok | output | 1 | Allocation succeeded |
| gnt_addr | output | ADDR_W | Byte address of the region, zero on failure |
| gnt_offset | output | log2(UNITS) | First unit of the region, zero on failure |
| gnt_units | output | MAXP_W+SLOT_W+2 | Units requested |
| free_valid | input | 1 | Release request |
| free_offset | input | log2(UNITS) | First unit to release |
| free_units | input | log2(UNITS)+1 | Number of units to release |

## Verification
On every cycle the assertions check the grant handshake. They check that each grant is a single-cycle pulse that ends a busy period, and that the reported unit count is never zero. For each grant they check that a failed grant carries a zero address, that a successful grant ends inside the capped limit, and that its address matches the base and offset. First-fit placement, the size rounding, and the fact that a failure or a repeated free leaves the occupancy intact cannot be seen from a single grant. Only the bench's sequences show them, because they observe where later requests land.

// File: rtl/fifo_seg_alloc.sv
module fifo_seg_alloc #(
  parameter int UNITS     = 128,
  parameter int UNIT_LOG2 = 9,
  parameter int ADDR_W    = 32,
  parameter int MAXP_W    = 11,
  parameter int SLOT_W    = 4,
  localparam int OFF_W    = $clog2(UNITS),
  localparam int LIM_W    = OFF_W + 1,
  localparam int TOT_W    = MAXP_W + SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              req_valid,
  input  logic [MAXP_W-1:0] req_maxp,
  input  logic [SLOT_W-1:0] req_slot,
  output logic              busy,
  output logic              gnt_valid,
  output logic              gnt_ok,
  output logic [ADDR_W-1:0] gnt_addr,
  output logic [OFF_W-1:0]  gnt_offset,
  output logic [TOT_W-1:0]  gnt_units,
  input  logic              free_valid,
  input  logic [OFF_W-1:0]  free_offset,
  input  logic [LIM_W-1:0]  free_units
);

  function automatic logic [UNITS-1:0] run_mask(input logic [TOT_W-1:0] n,
                                                input logic [LIM_W-1:0] at);
    logic [UNITS-1:0] m;
    if (n >= TOT_W'(UNITS)) m = '1;
    else m = (UNITS'(1) << n) - UNITS'(1);
    return m << at;
  endfunction

  function automatic logic [TOT_W-1:0] units_for(input logic [MAXP_W-1:0] maxp,
                                                 input logic [SLOT_W-1:0] slot);
    logic [TOT_W-1:0] seg, tot, n;
    seg = TOT_W'(1);
    for (int i = 0; i <= MAXP_W; i++)
      if (seg < TOT_W'(maxp)) seg = seg << 1;
    tot = seg * (TOT_W'(slot) + TOT_W'(1));
    n = (tot + TOT_W'((1 << UNIT_LOG2) - 1)) >> UNIT_LOG2;
    return (n == '0) ? TOT_W'(1) : n;
  endfunction

  logic [UNITS-1:0] bitmap_q;
  logic [TOT_W-1:0] need_q;
  logic [LIM_W-1:0] cand_q;
  logic             busy_q;

  logic [LIM_W-1:0] lim_eff;
  logic [TOT_W:0]   end_w;
  logic [UNITS-1:0] win, fmask;
  logic             no_room, hit;

  assign lim_eff = (cfg_limit > LIM_W'(UNITS)) ? LIM_W'(UNITS) : cfg_limit;
  assign end_w   = (TOT_W+1)'(cand_q) + (TOT_W+1)'(need_q);
  assign no_room = end_w > (TOT_W+1)'(lim_eff);
  assign win     = run_mask(need_q, cand_q);
  assign hit     = busy_q && !no_room && ((bitmap_q & win) == '0);
  assign fmask   = free_valid ? run_mask(TOT_W'(free_units), LIM_W'(free_offset)) : '0;
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitmap_q   <= '0;
      need_q     <= '0;
      cand_q     <= '0;
      busy_q     <= 1'b0;
      gnt_valid  <= 1'b0;
      gnt_ok     <= 1'b0;
      gnt_addr   <= '0;
      gnt_offset <= '0;
      gnt_units  <= '0;
    end else begin
      gnt_valid <= 1'b0;
      bitmap_q  <= (bitmap_q & ~fmask) | (hit ? win : '0);
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          need_q <= units_for(req_maxp, req_slot);
          cand_q <= '0;
        end
      end else if (hit || no_room) begin
        busy_q     <= 1'b0;
        gnt_valid  <= 1'b1;
        gnt_ok     <= hit;
        gnt_addr   <= hit ? cfg_base + (ADDR_W'(cand_q) << UNIT_LOG2) : '0;
        gnt_offset <= hit ? cand_q[OFF_W-1:0] : '0;
        gnt_units  <= need_q;
      end else begin
        cand_q <= cand_q + LIM_W'(1);
      end
    end
  end

endmodule

// File: rtl/fifo_seg_alloc_chk.sv
module fifo_seg_alloc_chk #(
  parameter int UNITS     = 128,
  parameter int UNIT_LOG2 = 9,
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 7,
  parameter int LIM_W     = 8,
  parameter int TOT_W     = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [LIM_W-1:0]  cfg_limit,
  input logic              busy,
  input logic              gnt_valid,
  input logic              gnt_ok,
  input logic [ADDR_W-1:0] gnt_addr,
  input logic [OFF_W-1:0]  gnt_offset,
  input logic [TOT_W-1:0]  gnt_units
);

  // R7
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> gnt_valid);

  // R7
  gnt_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $past(busy));

  // R5
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ok) |-> (gnt_addr == '0 && gnt_offset == '0));

  // R4
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ok) |->
      gnt_addr == $past(cfg_base) + (ADDR_W'(gnt_offset) << UNIT_LOG2));

  // R3
  in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ok) |->
      (int'(gnt_offset) + int'(gnt_units)) <=
      ((int'($past(cfg_limit)) > UNITS) ? UNITS : int'($past(cfg_limit))));

  // R2
  units_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_units != '0);

endmodule

bind fifo_seg_alloc fifo_seg_alloc_chk #(
  .UNITS(UNITS), .UNIT_LOG2(UNIT_LOG2), .ADDR_W(ADDR_W),
  .OFF_W(OFF_W), .LIM_W(LIM_W), .TOT_W(TOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
  .busy(busy), .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_addr(gnt_addr),
  .gnt_offset(gnt_offset), .gnt_units(gnt_units)
);

// File: tb/test_fifo_seg_alloc.sv
module test_fifo_seg_alloc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] cfg_base = 32'h0001_0000;
  logic [7:0]  cfg_limit = 8'd128;
  logic        req_valid = 0;
  logic [10:0] req_maxp = '0;
  logic [3:0]  req_slot = '0;
  logic        busy, gnt_valid, gnt_ok;
  logic [31:0] gnt_addr;
  logic [6:0]  gnt_offset;
  logic [16:0] gnt_units;
  logic        free_valid = 0;
  logic [6:0]  free_offset = '0;
  logic [7:0]  free_units = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fifo_seg_alloc i_fifo_seg_alloc (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .req_valid(req_valid), .req_maxp(req_maxp), .req_slot(req_slot),
    .busy(busy), .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_addr(gnt_addr),
    .gnt_offset(gnt_offset), .gnt_units(gnt_units),
    .free_valid(free_valid), .free_offset(free_offset), .free_units(free_units)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_gnt(output bit seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (gnt_valid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic alloc(int maxp, int slot, bit exp_ok, int exp_off, int exp_units, string req);
    bit seen;
    @(negedge clk);
    req_valid = 1; req_maxp = 11'(maxp); req_slot = 4'(slot);
    @(negedge clk) req_valid = 0;
    wait_gnt(seen);
    check({req, " grant seen"}, seen, 1);
    check({req, " ok"}, gnt_ok, exp_ok);
    check({req, " offset"}, gnt_offset, exp_ok ? exp_off : 0);
    check({req, " units"}, gnt_units, exp_units);
    check({req, " addr"}, gnt_addr, exp_ok ? cfg_base + 32'(exp_off) * 512 : 0);
  endtask

  task automatic release_units(int off, int n);
    @(negedge clk);
    free_valid = 1; free_offset = 7'(off); free_units = 8'(n);
    @(negedge clk) free_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy", busy, 0);
    check("R1 gnt_valid", gnt_valid, 0);
  endtask

  task automatic t_basic();
    alloc(512, 1, 1, 0, 2, "R2 R4 two units");
    alloc(100, 0, 1, 2, 1, "R3 R8 next free");
    alloc(1024, 3, 1, 3, 8, "R2 eight units");
    alloc(513, 0, 1, 11, 2, "R2 rounding");
  endtask

  task automatic t_free_reuse();
    release_units(0, 2);
    alloc(64, 2, 1, 0, 1, "R6 reuse freed");
    alloc(1000, 0, 1, 13, 2, "R3 skip small hole");
  endtask

  task automatic t_double_free();
    release_units(1, 1);
    release_units(1, 1);
    alloc(1, 0, 1, 1, 1, "R6 R2 min one");
    alloc(1, 0, 1, 15, 1, "R6 no extra release");
  endtask

  task automatic t_limit();
    cfg_limit = 8'd20;
    alloc(1024, 3, 0, 0, 8, "R5 no room");
    cfg_limit = 8'd24;
    alloc(1024, 3, 1, 16, 8, "R5 R3 exact fit after fail");
  endtask

  task automatic t_busy();
    bit seen;
    int grants = 0;
    cfg_limit = 8'd128;
    @(negedge clk);
    req_valid = 1; req_maxp = 11'd8; req_slot = 4'd0;
    @(negedge clk);
    req_maxp = 11'd2047; req_slot = 4'd15;
    check("R7 busy during search", busy, 1);
    @(negedge clk) req_valid = 0;
    for (int i = 0; i < 60; i++) begin
      if (gnt_valid) begin
        grants++;
        if (grants == 1) begin
          check("R7 first grant offset", gnt_offset, 24);
          check("R7 first grant units", gnt_units, 1);
          check("R7 busy low at grant", busy, 0);
        end
      end
      @(negedge clk);
    end
    check("R7 single grant", grants, 1);
    seen = 0;
  endtask

  task automatic t_base();
    cfg_base = 32'h4000_0000;
    alloc(200, 0, 1, 25, 1, "R4 new base");
  endtask

  task automatic t_full();
    do_reset();
    cfg_limit = 8'd255;
    alloc(2047, 15, 1, 0, 64, "R1 R3 cleared by reset");
    alloc(2047, 15, 1, 64, 64, "R3 clamp to 128");
    alloc(1, 0, 0, 0, 1, "R5 full");
    release_units(64, 64);
    alloc(1, 0, 1, 64, 1, "R6 R8 upper half freed");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_free_reuse();
    t_double_free();
    t_limit();
    t_busy();
    t_base();
    t_full();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule